// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two independent timer/counter units, each kept as a low byte and a high byte. A shared mode byte and a shared control byte select how the units run. Each unit advances either on a prescaled system clock (one step every twelve clocks by default) or on falling edges of its own external count pin. Each unit can also be gated by an external enable pin.

Four counting modes are available: a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads from a held value, and a split mode. In split mode unit 0 becomes two separate 8-bit counters, and its upper half takes over unit 1's overflow flag. Overflows set sticky flags that software clears through the control byte. Unit 1 also drives a one-cycle overflow pulse that a serial baud generator can use. Software reaches every register over a byte-wide write bus with a combinational read port.

Top module: `tmr_pair`

## Requirements
- R1: After reset every register reads 0x00, both flags are 0 and the overflow pulse is low.
- R2: Register addresses are 0 control, 1 mode, 2 unit-0 low, 3 unit-0 high, 4 unit-1 low and 5 unit-1 high. Addresses 6 and 7 read 0x00. Control bits 3:0 always read 0 and writes to them are dropped. Every other bit reads back the value written.
- R3: When the count-select bit is 0, a running unit advances exactly once per 12 system clocks.
- R4: When the count-select bit is 1, a running unit advances once per falling edge of its count pin, seen through a two-flop synchroniser. The count changes on the third rising clock edge after the pin falls.
- R5: A unit advances only when its run bit is 1 and either its gate bit is 0 or its synchronised gate pin is high. Otherwise its count holds.
- R6: Mode 0 counts a 13-bit value. Bits 4:0 of the low byte are the least significant bits and the whole high byte sits above them. Low-byte bits 7:5 are never changed by counting. Stepping from 0x1FFF wraps to 0 and sets the unit's flag.
- R7: Mode 1 counts {high, low} as 16 bits. Stepping from 0xFFFF wraps to 0 and sets the flag.
- R8: Mode 2 counts the low byte only. A step from 0xFF loads the low byte from the high byte and sets the flag. The high byte is unchanged.
- R9: Mode 3 on unit 0 splits it in two. The low byte is an 8-bit counter under unit 0's run, gate and count-select bits, and it sets flag 0. The high byte is an 8-bit counter on the prescaled clock under unit 1's run bit, and it sets flag 1.
- R10: While unit 0 is split, an overflow of unit 1 does not set flag 1. Unit 1 in mode 3 holds its count.
- R11: A flag stays 1 until a control write puts 0 in it. A control write decides the flag value even when an overflow happens in the same cycle.
- R12: Every overflow of unit 1 gives exactly one one-cycle pulse on the overflow pulse output in the following cycle. This holds whether or not unit 0 is split.
- Encodings: mode byte bits 7:4 configure unit 1 and bits 3:0 configure unit 0. Each nibble is, from MSB to LSB, gate, count-select, mode[1:0]. Control bits are 7 flag 1, 6 run 1, 5 flag 0 and 4 run 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 3 | Register address |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for sfr_addr |
| cnt_pin | input | 2 | Asynchronous count inputs, bit i for unit i |
| gate_pin | input | 2 | Asynchronous gate inputs, bit i for unit i |
| ovf_flag | output | 2 | Sticky overflow flags, bit 1 for unit 1 and bit 0 for unit 0 |
| t1_ovf_pulse | output | 1 | One-cycle pulse per unit-1 overflow |

## Verification
The assertions check on every cycle:
- the spacing of the prescaler tick;
- that both flags hold and that control writes take priority over flag setting;
- that a low-half overflow sets flag 0;
- that unit 1 cannot reach flag 1 while unit 0 is split;
- that the overflow pulse follows each unit-1 overflow and lasts one cycle;
- that a stopped unit keeps its low byte;
- that the reserved control bits read 0.

Only the bench scenarios can show the counting arithmetic of each mode against a separate model, the exact twelve-clock step rate, gate-pin qualification and the reload value. The same applies to the split-mode upper half running from the other run bit and to the exact cycle in which an overflow and a control write collide.

// File: rtl/tmr_pkg.sv
`timescale 1ns / 1ps
package tmr_pkg;

  localparam int BYTE_W  = 8;
  localparam int LOW13_W = 5;
  localparam int NUM_TMR = 2;
  localparam int ADDR_W  = 3;
  localparam int NIB_W   = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_TL0  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_TH0  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_TL1  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_TH1  = 3'd5;

  // control byte bit positions
  localparam int CB_TF1 = 7;
  localparam int CB_TR1 = 6;
  localparam int CB_TF0 = 5;
  localparam int CB_TR0 = 4;

  typedef enum logic [1:0] {
    MODE_13B   = 2'd0,
    MODE_16B   = 2'd1,
    MODE_8RL   = 2'd2,
    MODE_SPLIT = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      cnt_ext;
    tmr_mode_e mode;
  } tmr_cfg_t;

  typedef struct packed {
    logic [BYTE_W-1:0] tl;
    logic [BYTE_W-1:0] th;
    logic              ovf;
  } step_t;

  // one step of an 8-bit half: {carry, sum}
  function automatic logic [BYTE_W:0] byte_inc(input logic [BYTE_W-1:0] v);
    return {1'b0, v} + (BYTE_W+1)'(1);
  endfunction

  // one count step of the low/high pair in the given mode
  function automatic step_t step_count(input tmr_mode_e mode,
                                       input logic [BYTE_W-1:0] tl,
                                       input logic [BYTE_W-1:0] th);
    step_t             r;
    logic [LOW13_W:0]  lo_sum;
    logic [BYTE_W:0]   b_sum;
    logic [2*BYTE_W:0] w_sum;
    r      = '{tl: tl, th: th, ovf: 1'b0};
    lo_sum = '0;
    b_sum  = '0;
    w_sum  = '0;
    case (mode)
      MODE_13B: begin
        lo_sum = {1'b0, tl[LOW13_W-1:0]} + (LOW13_W+1)'(1);
        r.tl[LOW13_W-1:0] = lo_sum[LOW13_W-1:0];
        if (lo_sum[LOW13_W]) begin
          b_sum = byte_inc(th);
          r.th  = b_sum[BYTE_W-1:0];
          r.ovf = b_sum[BYTE_W];
        end
      end
      MODE_16B: begin
        w_sum = {1'b0, th, tl} + (2*BYTE_W+1)'(1);
        r.tl  = w_sum[BYTE_W-1:0];
        r.th  = w_sum[2*BYTE_W-1:BYTE_W];
        r.ovf = w_sum[2*BYTE_W];
      end
      MODE_8RL: begin
        if (&tl) begin
          r.tl  = th;
          r.ovf = 1'b1;
        end else begin
          r.tl = tl + BYTE_W'(1);
        end
      end
      default: begin
        b_sum = byte_inc(tl);
        r.tl  = b_sum[BYTE_W-1:0];
        r.ovf = b_sum[BYTE_W];
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns / 1ps
module tmr_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/tmr_pin_sync.sv
`timescale 1ns / 1ps
module tmr_pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_async,
  output logic [WIDTH-1:0] pin_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= pin_async;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/tmr_unit.sv
`timescale 1ns / 1ps
module tmr_unit
  import tmr_pkg::*;
#(
  parameter bit SPLIT_CAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_mode_e         mode,
  input  logic              adv_lo,
  input  logic              adv_hi,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] tl,
  output logic [BYTE_W-1:0] th,
  output logic              ovf_lo,
  output logic              ovf_hi
);
  logic [BYTE_W-1:0] tl_q, th_q;
  step_t             lo_step;
  logic [BYTE_W:0]   hi_step;
  logic              lo_active;
  logic              hi_split;

  // a unit without split capability is frozen in mode 3
  assign lo_active = adv_lo && (SPLIT_CAP || (mode != MODE_SPLIT));
  assign hi_split  = SPLIT_CAP && adv_hi && (mode == MODE_SPLIT);

  always_comb begin
    lo_step = step_count(mode, tl_q, th_q);
    hi_step = byte_inc(th_q);
  end

  assign ovf_lo = lo_active && lo_step.ovf;
  assign ovf_hi = hi_split && hi_step[BYTE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tl_q <= '0;
      th_q <= '0;
    end else begin
      if (wr_lo)          tl_q <= wdata;
      else if (lo_active) tl_q <= lo_step.tl;

      if (wr_hi)          th_q <= wdata;
      else if (hi_split)  th_q <= hi_step[BYTE_W-1:0];
      else if (lo_active) th_q <= lo_step.th;
    end
  end

  assign tl = tl_q;
  assign th = th_q;
endmodule

// File: rtl/tmr_pair.sv
`timescale 1ns / 1ps
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_we,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [BYTE_W-1:0] sfr_wdata,
  output logic [BYTE_W-1:0] sfr_rdata,
  input  logic [NUM_TMR-1:0] cnt_pin,
  input  logic [NUM_TMR-1:0] gate_pin,
  output logic [NUM_TMR-1:0] ovf_flag,
  output logic              t1_ovf_pulse
);
  logic [BYTE_W-1:0]  mode_q;
  logic [NUM_TMR-1:0] tr_q;
  logic [NUM_TMR-1:0] tf_q;
  logic               t1_pulse_q;

  logic               pre_tick;
  logic [NUM_TMR-1:0] cnt_lvl, gate_lvl, cnt_prev, cnt_fall;
  logic [NUM_TMR-1:0] adv_lo;
  tmr_cfg_t           cfg [NUM_TMR];

  logic              ctrl_wr;
  logic              t0_split, t0_adv_hi;
  logic [BYTE_W-1:0] t0_tl, t0_th, t1_tl, t1_th;
  logic              t0_ovf_lo, t0_ovf_hi, t1_ovf_lo, t1_ovf_hi;
  logic              tf1_set;

  tmr_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(pre_tick)
  );

  tmr_pin_sync #(.WIDTH(NUM_TMR), .STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(cnt_pin), .pin_sync(cnt_lvl)
  );

  tmr_pin_sync #(.WIDTH(NUM_TMR), .STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(gate_pin), .pin_sync(gate_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_prev <= '0;
    else        cnt_prev <= cnt_lvl;
  end
  assign cnt_fall = cnt_prev & ~cnt_lvl;

  // per-unit configuration decode and advance qualification
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_ctl
    logic gate_ok, src_tick;
    assign cfg[i]    = tmr_cfg_t'(mode_q[NIB_W*i +: NIB_W]);
    assign gate_ok   = !cfg[i].gate || gate_lvl[i];
    assign src_tick  = cfg[i].cnt_ext ? cnt_fall[i] : pre_tick;
    assign adv_lo[i] = tr_q[i] && gate_ok && src_tick;
  end

  assign t0_split  = (cfg[0].mode == MODE_SPLIT);
  assign t0_adv_hi = tr_q[1] && pre_tick;
  assign ctrl_wr   = sfr_we && (sfr_addr == ADDR_CTRL);

  tmr_unit #(.SPLIT_CAP(1'b1)) u_t0 (
    .clk(clk), .rst_n(rst_n), .mode(cfg[0].mode),
    .adv_lo(adv_lo[0]), .adv_hi(t0_adv_hi),
    .wr_lo(sfr_we && (sfr_addr == ADDR_TL0)),
    .wr_hi(sfr_we && (sfr_addr == ADDR_TH0)),
    .wdata(sfr_wdata), .tl(t0_tl), .th(t0_th),
    .ovf_lo(t0_ovf_lo), .ovf_hi(t0_ovf_hi)
  );

  tmr_unit #(.SPLIT_CAP(1'b0)) u_t1 (
    .clk(clk), .rst_n(rst_n), .mode(cfg[1].mode),
    .adv_lo(adv_lo[1]), .adv_hi(1'b0),
    .wr_lo(sfr_we && (sfr_addr == ADDR_TL1)),
    .wr_hi(sfr_we && (sfr_addr == ADDR_TH1)),
    .wdata(sfr_wdata), .tl(t1_tl), .th(t1_th),
    .ovf_lo(t1_ovf_lo), .ovf_hi(t1_ovf_hi)
  );

  // flag 1 belongs to unit 0's upper half while unit 0 is split
  assign tf1_set = t0_split ? t0_ovf_hi : (t1_ovf_lo || t1_ovf_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      tr_q       <= '0;
      tf_q       <= '0;
      t1_pulse_q <= 1'b0;
    end else begin
      t1_pulse_q <= t1_ovf_lo;
      if (sfr_we && (sfr_addr == ADDR_MODE)) mode_q <= sfr_wdata;
      if (ctrl_wr) begin
        tr_q <= {sfr_wdata[CB_TR1], sfr_wdata[CB_TR0]};
        tf_q <= {sfr_wdata[CB_TF1], sfr_wdata[CB_TF0]};
      end else begin
        if (t0_ovf_lo) tf_q[0] <= 1'b1;
        if (tf1_set)   tf_q[1] <= 1'b1;
      end
    end
  end

  always_comb begin
    sfr_rdata = '0;
    case (sfr_addr)
      ADDR_CTRL: begin
        sfr_rdata[CB_TF1] = tf_q[1];
        sfr_rdata[CB_TR1] = tr_q[1];
        sfr_rdata[CB_TF0] = tf_q[0];
        sfr_rdata[CB_TR0] = tr_q[0];
      end
      ADDR_MODE: sfr_rdata = mode_q;
      ADDR_TL0:  sfr_rdata = t0_tl;
      ADDR_TH0:  sfr_rdata = t0_th;
      ADDR_TL1:  sfr_rdata = t1_tl;
      ADDR_TH1:  sfr_rdata = t1_th;
      default:   sfr_rdata = '0;
    endcase
  end

  assign ovf_flag     = tf_q;
  assign t1_ovf_pulse = t1_pulse_q;
endmodule

// File: rtl/tmr_pair_checks.sv
`timescale 1ns / 1ps
module tmr_pair_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       sfr_we,
  input logic [2:0] sfr_addr,
  input logic [7:0] sfr_wdata,
  input logic [7:0] sfr_rdata,
  input logic [1:0] ovf_flag,
  input logic       t1_ovf_pulse,
  input logic       pre_tick,
  input logic       t0_adv_lo,
  input logic [7:0] t0_tl,
  input logic       t0_ovf_lo,
  input logic       t0_ovf_hi,
  input logic       t1_ovf_lo,
  input logic       t0_split
);
  logic ctrl_wr, tl0_wr;
  assign ctrl_wr = sfr_we && (sfr_addr == 3'd0);
  assign tl0_wr  = sfr_we && (sfr_addr == 3'd2);

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |=> !pre_tick); // R3

  AST_CTRL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == 3'd0) |-> (sfr_rdata[3:0] == 4'h0)); // R2

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!t0_adv_lo && !tl0_wr) |=> $stable(t0_tl)); // R5

  AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_ovf_lo && !ctrl_wr) |=> ovf_flag[0]); // R6

  AST_SPLIT_HI_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_split && t0_ovf_hi && !ctrl_wr) |=> ovf_flag[1]); // R9

  AST_SPLIT_T1_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_split && t1_ovf_lo && !t0_ovf_hi && !ovf_flag[1] && !ctrl_wr) |=> !ovf_flag[1]); // R10

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag[0] && !ctrl_wr) |=> ovf_flag[0]); // R11

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ovf_flag == {$past(sfr_wdata[7]), $past(sfr_wdata[5])})); // R11

  AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    t1_ovf_lo |=> t1_ovf_pulse); // R12

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    t1_ovf_pulse |=> !t1_ovf_pulse); // R12
endmodule

bind tmr_pair tmr_pair_checks u_checks (
  .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
  .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ovf_flag(ovf_flag),
  .t1_ovf_pulse(t1_ovf_pulse), .pre_tick(pre_tick), .t0_adv_lo(adv_lo[0]),
  .t0_tl(t0_tl), .t0_ovf_lo(t0_ovf_lo), .t0_ovf_hi(t0_ovf_hi),
  .t1_ovf_lo(t1_ovf_lo), .t0_split(t0_split)
);

// File: tb/tmr_pair_bench.sv
`timescale 1ns / 1ps
module tmr_pair_bench;
  localparam logic [2:0] A_CTRL = 3'd0, A_MODE = 3'd1, A_TL0 = 3'd2,
                         A_TH0 = 3'd3, A_TL1 = 3'd4, A_TH1 = 3'd5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sfr_we;
  logic [2:0] sfr_addr;
  logic [7:0] sfr_wdata, sfr_rdata;
  logic [1:0] cnt_pin, gate_pin, ovf_flag;
  logic       t1_ovf_pulse;
  int         checks = 0, errors = 0, pulse_seen = 0;

  always #2.5 clk = ~clk;

  tmr_pair u_tmr_pair (
    .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .ovf_flag(ovf_flag), .t1_ovf_pulse(t1_ovf_pulse)
  );

  always @(negedge clk) if (rst_n && t1_ovf_pulse) pulse_seen++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(posedge clk);
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    sfr_addr = a;
    #1;
    d = sfr_rdata;
  endtask

  task automatic events(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      cnt_pin[idx] = 1'b0;
      repeat (3) @(negedge clk);
      cnt_pin[idx] = 1'b1;
      repeat (3) @(negedge clk);
    end
  endtask

  // reference model of n count steps, written from the requirements
  function automatic void model(input logic [1:0] m, input logic [7:0] tl, input logic [7:0] th,
                                input int n, output logic [7:0] otl, output logic [7:0] oth,
                                output int novf);
    int v, l;
    novf = 0;
    otl = tl; oth = th;
    if (m == 2'd0) begin
      v = th * 32 + tl[4:0];
      for (int i = 0; i < n; i++) begin
        v++;
        if (v == 8192) begin v = 0; novf++; end
      end
      otl = {tl[7:5], 5'(v % 32)};
      oth = 8'(v / 32);
    end else if (m == 2'd1) begin
      v = th * 256 + tl;
      for (int i = 0; i < n; i++) begin
        v++;
        if (v == 65536) begin v = 0; novf++; end
      end
      otl = 8'(v % 256);
      oth = 8'(v / 256);
    end else begin
      l = tl;
      for (int i = 0; i < n; i++) begin
        if (l == 255) begin l = th; novf++; end
        else l++;
      end
      otl = 8'(l);
    end
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, etl, eth, rtl_v, rth_v, rct, vtl, vth;
    logic [1:0] m;
    int         t, n, novf;
    string      rq;

    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; sfr_we = 1'b0; sfr_addr = '0; sfr_wdata = '0;
    cnt_pin = 2'b11; gate_pin = 2'b00;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk(d == 8'h00, "R1 reset register", d, 0);
    end
    chk(ovf_flag == 2'b00, "R1 reset flags", ovf_flag, 0);
    chk(t1_ovf_pulse == 1'b0, "R1 reset pulse", t1_ovf_pulse, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 register map, readback and reserved bits
    wr(A_TL0, 8'h12); wr(A_TH0, 8'h34); wr(A_TL1, 8'h56); wr(A_TH1, 8'h78);
    wr(A_MODE, 8'h5A);
    rd(A_TL0, d);  chk(d == 8'h12, "R2 low0", d, 8'h12);
    rd(A_TH0, d);  chk(d == 8'h34, "R2 high0", d, 8'h34);
    rd(A_TL1, d);  chk(d == 8'h56, "R2 low1", d, 8'h56);
    rd(A_TH1, d);  chk(d == 8'h78, "R2 high1", d, 8'h78);
    rd(A_MODE, d); chk(d == 8'h5A, "R2 mode", d, 8'h5A);
    wr(A_MODE, 8'h00);
    wr(A_CTRL, 8'h0F);
    rd(A_CTRL, d); chk(d == 8'h00, "R2 ctrl low nibble", d, 0);
    rd(3'd6, d);   chk(d == 8'h00, "R2 unmapped", d, 0);
    wr(A_CTRL, 8'hA0);
    rd(A_CTRL, d); chk(d == 8'hA0, "R2 ctrl flags", d, 8'hA0);
    chk(ovf_flag == 2'b11, "R2 flag outputs", ovf_flag, 3);
    wr(A_CTRL, 8'h00);
    chk(ovf_flag == 2'b00, "R11 flags cleared by write", ovf_flag, 0);

    // R4 R6 R7 R8 R12 random event counting on both units
    for (int it = 0; it < 24; it++) begin
      t = $urandom_range(1, 0);
      m = 2'($urandom_range(2, 0));
      vtl = 8'($urandom); vth = 8'($urandom);
      n = $urandom_range(40, 0);
      if (it < 3) begin vtl = 8'hFF; vth = 8'hFF; n = 2; end
      rq = (m == 2'd0) ? "R4/R6" : (m == 2'd1) ? "R4/R7" : "R4/R8";
      wr(A_MODE, t ? {2'b01, m, 4'h0} : {4'h0, 2'b01, m});
      wr(A_CTRL, 8'h00);
      wr(t ? A_TL1 : A_TL0, vtl);
      wr(t ? A_TH1 : A_TH0, vth);
      pulse_seen = 0;
      wr(A_CTRL, t ? 8'h40 : 8'h10);
      events(t, n);
      repeat (2) @(negedge clk);
      rd(t ? A_TL1 : A_TL0, rtl_v);
      rd(t ? A_TH1 : A_TH0, rth_v);
      rd(A_CTRL, rct);
      model(m, vtl, vth, n, etl, eth, novf);
      chk(rtl_v == etl, rq, rtl_v, etl);
      chk(rth_v == eth, rq, rth_v, eth);
      chk((t ? rct[7] : rct[5]) == (novf > 0), "R11 sticky flag", t ? rct[7] : rct[5], novf > 0);
      if (t) chk(pulse_seen == novf, "R12 pulse count", pulse_seen, novf);
      wr(A_CTRL, 8'h00);
    end

    // R6 directed: 13-bit wrap keeps low-byte bits 7:5
    wr(A_MODE, 8'h04); wr(A_TL0, 8'hFF); wr(A_TH0, 8'hFF); wr(A_CTRL, 8'h10);
    events(0, 1); repeat (2) @(negedge clk);
    rd(A_TL0, d); chk(d == 8'hE0, "R6 wrap low", d, 8'hE0);
    rd(A_TH0, d); chk(d == 8'h00, "R6 wrap high", d, 0);
    chk(ovf_flag[0] == 1'b1, "R6 flag", ovf_flag[0], 1);
    wr(A_CTRL, 8'h00);

    // R8 directed reload
    wr(A_MODE, 8'h06); wr(A_TL0, 8'hFF); wr(A_TH0, 8'h80); wr(A_CTRL, 8'h10);
    events(0, 2); repeat (2) @(negedge clk);
    rd(A_TL0, d); chk(d == 8'h81, "R8 reload then step", d, 8'h81);
    rd(A_TH0, d); chk(d == 8'h80, "R8 high unchanged", d, 8'h80);
    wr(A_CTRL, 8'h00);

    // R3 timer mode: 5 ticks in 60 clocks, overflow on the third
    wr(A_MODE, 8'h01); wr(A_TL0, 8'hFD); wr(A_TH0, 8'hFF);
    wr(A_CTRL, 8'h10);
    repeat (12 * 5 - 1) @(negedge clk);
    rd(A_CTRL, d); chk(d[5] == 1'b1, "R3/R7 flag in timer mode", d[5], 1);
    wr(A_CTRL, 8'h00);
    rd(A_TL0, d); chk(d == 8'h02, "R3 tick count low", d, 8'h02);
    rd(A_TH0, d); chk(d == 8'h00, "R3 tick count high", d, 0);
    wr(A_TL0, 8'h00); wr(A_TH0, 8'h00); wr(A_CTRL, 8'h10);
    repeat (12 * 7 - 1) @(negedge clk);
    wr(A_CTRL, 8'h00);
    rd(A_TL0, d); chk(d == 8'h07, "R3 seven ticks", d, 8'h07);

    // R5 run bit and gate pin
    wr(A_MODE, 8'h05); wr(A_TL0, 8'h00); wr(A_TH0, 8'h00);
    events(0, 3); repeat (2) @(negedge clk);
    rd(A_TL0, d); chk(d == 8'h00, "R5 stopped unit holds", d, 0);
    wr(A_MODE, 8'h0D); gate_pin = 2'b00; wr(A_CTRL, 8'h10);
    events(0, 3); repeat (2) @(negedge clk);
    rd(A_TL0, d); chk(d == 8'h00, "R5 gate low blocks", d, 0);
    gate_pin = 2'b01; repeat (3) @(negedge clk);
    events(0, 2); repeat (2) @(negedge clk);
    rd(A_TL0, d); chk(d == 8'h02, "R5 gate high counts", d, 8'h02);
    gate_pin = 2'b00;
    wr(A_CTRL, 8'h00);

    // R9 R10 R12 split mode
    wr(A_MODE, 8'h67); wr(A_TL0, 8'hFE); wr(A_TH0, 8'hF0);
    wr(A_TL1, 8'hFF); wr(A_TH1, 8'h10);
    pulse_seen = 0;
    wr(A_CTRL, 8'h50);
    events(0, 2); events(1, 1); repeat (2) @(negedge clk);
    rd(A_TL0, d); chk(d == 8'h00, "R9 low half wraps", d, 0);
    chk(ovf_flag[0] == 1'b1, "R9 low half flag", ovf_flag[0], 1);
    rd(A_TL1, d); chk(d == 8'h10, "R10 unit1 reload in split", d, 8'h10);
    chk(ovf_flag[1] == 1'b0, "R10 unit1 cannot set flag", ovf_flag[1], 0);
    chk(pulse_seen == 1, "R12 pulse while split", pulse_seen, 1);
    wr(A_CTRL, 8'h00);
    wr(A_TL0, 8'h00); wr(A_TH0, 8'hFE);
    wr(A_CTRL, 8'h40);
    repeat (12 * 4 - 1) @(negedge clk);
    rd(A_CTRL, d); chk(d[7] == 1'b1, "R9 high half sets flag1", d[7], 1);
    wr(A_CTRL, 8'h00);
    rd(A_TH0, d); chk(d == 8'h02, "R9 high half under run1", d, 8'h02);
    rd(A_TL0, d); chk(d == 8'h00, "R9 low half idle", d, 0);

    // R10 unit 1 in mode 3 holds
    wr(A_MODE, 8'h71); wr(A_TL1, 8'h3C); wr(A_TH1, 8'h4D); wr(A_CTRL, 8'h40);
    events(1, 2); repeat (2) @(negedge clk);
    rd(A_TL1, d); chk(d == 8'h3C, "R10 mode3 unit1 low holds", d, 8'h3C);
    rd(A_TH1, d); chk(d == 8'h4D, "R10 mode3 unit1 high holds", d, 8'h4D);
    wr(A_CTRL, 8'h00);

    // R11 control write collides with an overflow
    wr(A_MODE, 8'h06); wr(A_TL0, 8'hFF); wr(A_TH0, 8'h33); wr(A_CTRL, 8'h10);
    cnt_pin[0] = 1'b0;
    @(negedge clk); @(negedge clk);
    wr(A_CTRL, 8'h10);
    rd(A_CTRL, d); chk(d[5] == 1'b0, "R11 write beats overflow", d[5], 0);
    rd(A_TL0, d);  chk(d == 8'h33, "R11 reload on collision", d, 8'h33);
    cnt_pin[0] = 1'b1;
    repeat (5) @(negedge clk);
    chk(ovf_flag[0] == 1'b0, "R11 flag stays clear", ovf_flag[0], 0);
    wr(A_CTRL, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule